// File: doc/BRIEF.md
# Motion Watchdog and Interrupt Controller

This block is the global supervisor of a multi-axis motion card. It turns the PWM period strobe into a periodic interrupt at a programmable fraction of the PWM rate, and it flags an interrupt that arrives while the previous one is still uncleared. It can also emit a counter-latch strobe on every interrupt event. A microsecond watchdog counts down from a reloadable timeout. A watchdog expiry, a missed interrupt, or both can force the global PWM enable low.

Software drives the block through a small register bus. Writes to the command register act as one-cycle strobes and never need to be cleared. The mode register holds the control bits and shows two live status bits. The strobes to the counters and PWM channels leave the block as single-cycle pulses. The counters and PWM channels are outside it.

Register indices (wr_addr / rd_addr): 0 = command (write-only, reads 0), 1 = mode, 2 = interrupt divider (8 bits), 3 = watchdog timeout (16 bits), 4 = watchdog count (read-only). Read data is registered and appears one clock after rd_addr is presented.

Top module: `motion_supervisor`

## Requirements
- R1: An interrupt event occurs on every (D+1)-th PWM period strobe, where D is the divider register value. Writing the divider restarts the strobe count from zero. The event raises the pending flag one clock after the completing strobe.
- R2: A write to register 0 with data bit 0 produces one single-cycle ctr_clear pulse. Bit 1 produces a ctr_latch pulse and bit 2 produces a pwm_clear pulse. Each pulse appears in the clock after the write. Bits written as 0 produce nothing.
- R3: Mode bit 0 drives ctr_enable. Mode bit 1 drives pwm_enable unless a stop condition (R5, R8) applies.
- R4: With mode bit 2 set, every interrupt event emits one ctr_latch pulse, in the same clock in which pending rises.
- R5: An interrupt event that arrives while the interrupt is still pending sets the missed flag, which reads as mode bit 4. With mode bit 3 set, a set missed flag holds pwm_enable low.
- R6: irq is high only while the interrupt is pending and mode bit 5 is 1. Mode bit 6 reads the pending flag whatever the mask. Command bit 3 clears both pending and missed.
- R7: Command bit 4 loads the watchdog count from the timeout register and clears wd_expired. The count then drops by one every 33 clocks. When it reaches zero, wd_expired is set in the same clock and the count stays at zero.
- R8: With mode bit 7 set, an expired watchdog holds pwm_enable low.
- R9: Mode bits 4 and 6 are read-only. Values written to them are ignored.
- R10: A timeout of zero loaded by a reload leaves the watchdog idle, and wd_expired stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register index |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register index |
| rd_data | output | 16 | Registered read data |
| pwm_period_pulse | input | 1 | One-clock strobe per PWM period |
| ctr_clear | output | 1 | Clear-all-counters pulse |
| ctr_latch | output | 1 | Latch-all-counters pulse |
| pwm_clear | output | 1 | Clear-all-PWM pulse |
| ctr_enable | output | 1 | Global counter enable |
| pwm_enable | output | 1 | Global PWM enable after stop conditions |
| irq | output | 1 | Masked interrupt request |
| wd_expired | output | 1 | Sticky watchdog timeout |

## Verification
The bench sweeps the divider over the values 0 to 5 and counts latch strobes against floor(strobes/(D+1)). An off-by-one divider, or one that keeps its count across a rewrite, shows a wrong count. It times watchdog expiry to the exact clock at N*33. A prescaler that is off by one cycle, or that skips its restart on reload, moves the edge. It also checks that the count freezes at zero and that a zero timeout never expires. It drives a second event before a clear to catch a missed flag that does not set, or a stop-on-missed that fails to gate the PWM. It writes ones to the read-only mode bits to catch a design that stores them.

// File: rtl/motion_sup_pkg.sv
package motion_sup_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] REG_DIV  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_WDTO = 3'd3;
  localparam logic [ADDR_W-1:0] REG_WDCT = 3'd4;

  // command bit positions
  localparam int CMD_CCLR = 0;
  localparam int CMD_CLAT = 1;
  localparam int CMD_PCLR = 2;
  localparam int CMD_ICLR = 3;
  localparam int CMD_WDLD = 4;

  // mode bit positions
  localparam int MD_CEN  = 0;
  localparam int MD_PEN  = 1;
  localparam int MD_LOI  = 2;
  localparam int MD_SOM  = 3;
  localparam int MD_MISS = 4;
  localparam int MD_MASK = 5;
  localparam int MD_PEND = 6;
  localparam int MD_SOT  = 7;
  localparam logic [7:0] MODE_WR_MASK = 8'hAF;
endpackage

// File: rtl/msup_irq_div.sv
module msup_irq_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             pwm_pulse,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (pwm_pulse) begin
      if (cnt_q >= div_val) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  AST_TICK_FROM_PULSE: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(pwm_pulse)); // R1
endmodule

// File: rtl/msup_irq_ctrl.sv
module msup_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic clear,
  output logic pending,
  output logic missed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      missed  <= 1'b0;
    end else if (event_in) begin
      pending <= 1'b1;
      missed  <= clear ? 1'b0 : (missed | pending);
    end else if (clear) begin
      pending <= 1'b0;
      missed  <= 1'b0;
    end
  end

  AST_MISSED_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    missed |-> pending); // R5
  AST_CLEAR_DROPS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (clear && !event_in) |=> !pending); // R6
endmodule

// File: rtl/msup_wdog.sv
module msup_wdog #(
  parameter int WD_W     = 16,
  parameter int TICK_DIV = 33
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reload,
  input  logic [WD_W-1:0] timeout,
  output logic [WD_W-1:0] count,
  output logic            expired
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [WD_W-1:0]  ONE      = WD_W'(1);

  logic [PRE_W-1:0] presc_q;
  logic             us_tick;

  assign us_tick = (presc_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || reload || us_tick) presc_q <= '0;
    else                          presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (reload) begin
      count   <= timeout;
      expired <= 1'b0;
    end else if (us_tick && count != '0) begin
      count <= count - ONE;
      if (count == ONE) expired <= 1'b1;
    end
  end

  AST_WD_STEP: assert property (@(posedge clk) disable iff (rst)
    !reload |=> (count == $past(count) || count == $past(count) - ONE)); // R7
  AST_WD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (expired && !reload) |=> (expired && count == '0)); // R7
endmodule

// File: rtl/motion_supervisor.sv
module motion_supervisor #(
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 8,
  parameter int WD_W     = 16,
  parameter int TICK_DIV = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwm_period_pulse,
  output logic              ctr_clear,
  output logic              ctr_latch,
  output logic              pwm_clear,
  output logic              ctr_enable,
  output logic              pwm_enable,
  output logic              irq,
  output logic              wd_expired
);
  import motion_sup_pkg::*;

  logic [7:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [WD_W-1:0]  wd_to_q;
  logic [WD_W-1:0]  wd_cnt;
  logic             cmd_hit, div_hit;
  logic             irq_clear, wd_reload;
  logic             irq_tick, pending, missed;
  logic [7:0]       mode_view;

  assign cmd_hit   = wr_en && (wr_addr == REG_CMD);
  assign div_hit   = wr_en && (wr_addr == REG_DIV);
  assign irq_clear = cmd_hit && wr_data[CMD_ICLR];
  assign wd_reload = cmd_hit && wr_data[CMD_WDLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      div_q   <= '0;
      wd_to_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_MODE: mode_q  <= wr_data[7:0] & MODE_WR_MASK;
        REG_DIV:  div_q   <= wr_data[DIV_W-1:0];
        REG_WDTO: wd_to_q <= wr_data[WD_W-1:0];
        default: ;
      endcase
    end
  end

  msup_irq_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(div_hit),
    .pwm_pulse(pwm_period_pulse), .div_val(div_q), .tick(irq_tick));

  msup_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .event_in(irq_tick), .clear(irq_clear),
    .pending(pending), .missed(missed));

  msup_wdog #(.WD_W(WD_W), .TICK_DIV(TICK_DIV)) u_wd (
    .clk(clk), .rst(rst), .reload(wd_reload), .timeout(wd_to_q),
    .count(wd_cnt), .expired(wd_expired));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_clear <= 1'b0;
      ctr_latch <= 1'b0;
      pwm_clear <= 1'b0;
    end else begin
      ctr_clear <= cmd_hit && wr_data[CMD_CCLR];
      ctr_latch <= (cmd_hit && wr_data[CMD_CLAT]) || (irq_tick && mode_q[MD_LOI]);
      pwm_clear <= cmd_hit && wr_data[CMD_PCLR];
    end
  end

  always_comb begin
    mode_view          = mode_q;
    mode_view[MD_MISS] = missed;
    mode_view[MD_PEND] = pending;
  end

  assign ctr_enable = mode_q[MD_CEN];
  assign pwm_enable = mode_q[MD_PEN]
                    & ~(mode_q[MD_SOM] & missed)
                    & ~(mode_q[MD_SOT] & wd_expired);
  assign irq = pending & mode_q[MD_MASK];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        REG_MODE: rd_data <= DATA_W'(mode_view);
        REG_DIV:  rd_data <= DATA_W'(div_q);
        REG_WDTO: rd_data <= DATA_W'(wd_to_q);
        REG_WDCT: rd_data <= DATA_W'(wd_cnt);
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_CMD_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    (ctr_clear || pwm_clear) |-> $past(wr_en)); // R2
  AST_SOT_GATES_PWM: assert property (@(posedge clk) disable iff (rst)
    (mode_q[MD_SOT] && wd_expired) |-> !pwm_enable); // R8
  AST_SOM_GATES_PWM: assert property (@(posedge clk) disable iff (rst)
    (mode_q[MD_SOM] && missed) |-> !pwm_enable); // R5
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq |-> pending); // R6
endmodule

// File: tb/tb_motion_supervisor.sv
module tb_motion_supervisor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_period_pulse = 1'b0;
  logic        ctr_clear, ctr_latch, pwm_clear, ctr_enable, pwm_enable, irq, wd_expired;

  int errors = 0;
  int checks = 0;
  int n_latch = 0;
  int n_cclr = 0;
  int n_pclr = 0;

  always #2.5 clk = ~clk;

  motion_supervisor dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_period_pulse(pwm_period_pulse),
    .ctr_clear(ctr_clear), .ctr_latch(ctr_latch), .pwm_clear(pwm_clear),
    .ctr_enable(ctr_enable), .pwm_enable(pwm_enable), .irq(irq),
    .wd_expired(wd_expired));

  always @(negedge clk) begin
    if (ctr_latch) n_latch++;
    if (ctr_clear) n_cclr++;
    if (pwm_clear) n_pclr++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic pulse();
    @(negedge clk);
    pwm_period_pulse = 1'b1;
    @(negedge clk);
    pwm_period_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, base, base2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R3 reset enables", {ctr_enable, pwm_enable}, 0);
    chk("R6 reset irq", irq, 0);
    chk("R7 reset expired", wd_expired, 0);
    rd(3'd1, v); chk("R9 reset mode", v, 0);
    rd(3'd4, v); chk("R7 reset count", v, 0);

    // R2 command pulses
    base = n_cclr;
    wr(3'd0, 16'h0001);
    chk("R2 ctr_clear pulse", ctr_clear, 1);
    @(negedge clk);
    chk("R2 ctr_clear single", ctr_clear, 0);
    chk("R2 ctr_clear count", n_cclr - base, 1);
    base = n_latch; base2 = n_pclr;
    wr(3'd0, 16'h0006);
    chk("R2 latch+pwm pulse", {ctr_latch, pwm_clear}, 3);
    wr(3'd0, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R2 zero write no latch", n_latch - base, 1);
    chk("R2 zero write no pwmclr", n_pclr - base2, 1);

    // R3 enables
    wr(3'd1, 16'h0003);
    chk("R3 enables on", {ctr_enable, pwm_enable}, 3);
    wr(3'd1, 16'h0002);
    chk("R3 ctr off pwm on", {ctr_enable, pwm_enable}, 1);

    // R1/R4 divider sweep with latch on interrupt
    for (int d = 0; d <= 5; d++) begin
      wr(3'd1, 16'h0004);
      wr(3'd2, 16'(d));
      wr(3'd0, 16'h0008);
      base = n_latch;
      for (int p = 0; p < 12; p++) pulse();
      repeat (3) @(negedge clk);
      chk($sformatf("R1 R4 events div=%0d", d), n_latch - base, 12 / (d + 1));
    end

    // R1 same-clock alignment of latch and pending, R6 mask
    wr(3'd1, 16'h0004);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h0008);
    @(negedge clk);
    pwm_period_pulse = 1'b1;
    @(negedge clk);
    pwm_period_pulse = 1'b0;
    chk("R1 pending not yet", irq, 0);
    @(negedge clk);
    chk("R4 latch with event", ctr_latch, 1);
    rd(3'd1, v);
    chk("R6 pending visible masked", v, 16'h0044);
    chk("R6 irq masked", irq, 0);
    wr(3'd1, 16'h0020);
    chk("R6 irq unmasked", irq, 1);
    wr(3'd0, 16'h0008);
    chk("R6 irq cleared", irq, 0);

    // R5 missed interrupt with stop-on-missed
    wr(3'd1, 16'h000A);
    chk("R5 pwm on before", pwm_enable, 1);
    pulse();
    chk("R5 single event no stop", pwm_enable, 1);
    pulse();
    rd(3'd1, v);
    chk("R5 missed status", v, 16'h005A);
    chk("R5 pwm stopped", pwm_enable, 0);
    wr(3'd0, 16'h0008);
    rd(3'd1, v);
    chk("R5 R6 clear drops both", v, 16'h000A);
    chk("R5 pwm restored", pwm_enable, 1);

    // R9 read-only bits
    wr(3'd1, 16'h0050);
    rd(3'd1, v);
    chk("R9 ro bits ignored", v, 0);

    // R7/R8 watchdog timing
    wr(3'd1, 16'h0082);
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0010);
    repeat (98) @(posedge clk);
    @(negedge clk);
    chk("R7 not yet expired", wd_expired, 0);
    chk("R8 pwm still on", pwm_enable, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 expired on time", wd_expired, 1);
    chk("R8 pwm forced off", pwm_enable, 0);
    repeat (100) @(negedge clk);
    rd(3'd4, v);
    chk("R7 count held at zero", v, 0);
    chk("R7 expired sticky", wd_expired, 1);

    // R7 readback mid-count and reload clears
    wr(3'd3, 16'd100);
    wr(3'd0, 16'h0010);
    chk("R7 reload clears", wd_expired, 0);
    repeat (10 * 33 + 14) @(negedge clk);
    rd(3'd4, v);
    chk("R7 count readback", v, 90);

    // R10 zero timeout
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0010);
    repeat (200) @(negedge clk);
    chk("R10 zero timeout idle", wd_expired, 0);
    chk("R10 pwm stays on", pwm_enable, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule